// File: doc/BRIEF.md
# Signed Halfword Multiply-Accumulate

This block is the arithmetic core behind a family of signed DSP multiply instructions that work on 16-bit halves of 32-bit words. It accepts one operation per cycle. The inputs are an operation code, two operand words, an accumulate word (or a high/low accumulate pair), and two half-select bits. The result word or result pair appears one clock later, together with a single-cycle pulse. That pulse reports a signed overflow on a 32-bit accumulate.

The surrounding pipeline reads the register file, decodes the instruction and writes back the result. It ORs the overflow pulse into its own sticky saturation status bit. The block never saturates: an overflowing accumulate still returns the two's-complement wrapped sum. The multiplier is either one shared wide array or a split pair of arrays, selected by a parameter.

Top module: `halfmul_acc`

## Requirements
- R1: After reset `out_valid`, `res_lo`, `res_hi` and `ovf_set` are zero. `out_valid` rises exactly one clock after a cycle with `in_valid` high, and the registered results belong to that operation.
- R2: When `sel_a_hi` is 1, the halfword taken from `opnd_a` is bits 31:16; when it is 0, bits 15:0 are taken. `sel_b_hi` picks the `opnd_b` halfword the same way. Every selected halfword is treated as signed, sign-extended from its bit 15.
- R3: Op code 0 (halfword multiply-accumulate) gives `res_lo` = product + `acc_lo` modulo 2^32 and `res_hi` = 0. `ovf_set` is 1 exactly when the signed 32-bit addition overflows.
- R4: Op code 1 (halfword multiply) gives `res_lo` = signed 16x16 product and `res_hi` = 0. It never raises `ovf_set`.
- R5: Op code 3 (word-by-half multiply) multiplies all 32 signed bits of `opnd_a` by the selected signed halfword of `opnd_b`. It returns bits 47:16 of the 48-bit product in `res_lo`, with `res_hi` = 0. `sel_a_hi` has no effect and `ovf_set` stays 0.
- R6: Op code 2 (word-by-half multiply-accumulate) adds the R5 slice to `acc_lo` modulo 2^32, with `res_hi` = 0. `ovf_set` is 1 exactly when that signed addition overflows.
- R7: Op code 4 (long accumulate) forms {`acc_hi`,`acc_lo`} + the sign-extended 16x16 product modulo 2^64 and returns it in {`res_hi`,`res_lo`}. Carries and borrows propagate across the word boundary, and `ovf_set` stays 0.
- R8: `ovf_set` is a one-cycle pulse that is only ever high together with `out_valid`.
- R9: Op codes 5, 6 and 7 return a zero result pair and no overflow pulse.
- R10: In a cycle after `in_valid` was low, `out_valid` and `ovf_set` are 0 and `res_lo`/`res_hi` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | Operation select (0..4 used, 5..7 reserved) |
| opnd_a | input | DATA_W | First operand word |
| opnd_b | input | DATA_W | Second operand word |
| acc_lo | input | DATA_W | Accumulate word / low word of pair |
| acc_hi | input | DATA_W | High word of accumulate pair |
| sel_a_hi | input | 1 | Upper-half select for `opnd_a` |
| sel_b_hi | input | 1 | Upper-half select for `opnd_b` |
| out_valid | output | 1 | Registered result valid |
| res_lo | output | DATA_W | Result word / low word of pair |
| res_hi | output | DATA_W | High word of result pair |
| ovf_set | output | 1 | Pulse: signed overflow on 32-bit accumulate |

## Verification
The bench targets the halfword products at the extremes, such as -32768 times -32768 and -32768 times 32767. It pairs them with accumulate words that push the sum just past either signed limit. A design that saturated instead of wrapping would return 0x7FFFFFFF or 0x80000000, and one that tested overflow on the wrong bit would miss the pulse or raise it falsely. The long-accumulate cases carry and borrow across the word boundary, so a design that sign-extended the product into the high word wrongly, or dropped the carry, would corrupt `res_hi`. Word-by-half cases use a negative full word with the upper-half select toggled, so a slice taken at the wrong offset, or a design that let `sel_a_hi` reach the wide form, would show up in `res_lo`.

// File: rtl/halfmul_pkg.sv
package halfmul_pkg;

   // Operation codes seen on op_code; values 5..7 are reserved.
   typedef enum logic [2:0] {
      HM_MLA_H = 3'd0,   // 16x16 + 32-bit accumulate
      HM_MUL_H = 3'd1,   // 16x16 product only
      HM_MLA_W = 3'd2,   // 32x16, upper slice + 32-bit accumulate
      HM_MUL_W = 3'd3,   // 32x16, upper slice only
      HM_MLA_L = 3'd4    // 16x16 + 64-bit pair accumulate
   } hm_op_e;

   // True for the operations that use the whole first operand word.
   function automatic logic hm_is_wide(input logic [2:0] code);
      return (code == HM_MLA_W) || (code == HM_MUL_W);
   endfunction

endpackage

// File: rtl/halfmul_opsel.sv
// Picks one halfword out of a word.
module halfmul_opsel #(
   parameter int DATA_W = 32,
   localparam int HALF_W = DATA_W / 2
) (
   input  logic [DATA_W-1:0] word_in,
   input  logic              take_hi,
   output logic [HALF_W-1:0] half_out
);

   assign half_out = take_hi ? word_in[DATA_W-1:HALF_W] : word_in[HALF_W-1:0];

endmodule

// File: rtl/halfmul_mult.sv
// Signed multiplier producing a DATA_W+HALF_W product.
// SHARED=1: one wide array serves every form.
// SHARED=0: a narrow half x half array plus a wide word x half array.
module halfmul_mult #(
   parameter int DATA_W = 32,
   parameter bit SHARED = 1'b1,
   localparam int HALF_W = DATA_W / 2,
   localparam int PROD_W = DATA_W + HALF_W
) (
   input  logic              wide_mode,
   input  logic [DATA_W-1:0] a_word,
   input  logic [HALF_W-1:0] a_half,
   input  logic [HALF_W-1:0] b_half,
   output logic [PROD_W-1:0] product
);

   logic signed [PROD_W-1:0] b_ext;
   assign b_ext = {{(PROD_W-HALF_W){b_half[HALF_W-1]}}, b_half};

   generate
      if (SHARED) begin : g_shared
         logic        [DATA_W-1:0] a_pick;
         logic signed [PROD_W-1:0] a_ext;
         assign a_pick  = wide_mode ? a_word
                                    : {{(DATA_W-HALF_W){a_half[HALF_W-1]}}, a_half};
         assign a_ext   = {{(PROD_W-DATA_W){a_pick[DATA_W-1]}}, a_pick};
         assign product = a_ext * b_ext;
      end else begin : g_split
         logic signed [DATA_W-1:0] ah_ext;
         logic signed [DATA_W-1:0] bh_ext;
         logic signed [DATA_W-1:0] p_narrow;
         logic signed [PROD_W-1:0] aw_ext;
         logic signed [PROD_W-1:0] p_wide;
         assign ah_ext   = {{(DATA_W-HALF_W){a_half[HALF_W-1]}}, a_half};
         assign bh_ext   = {{(DATA_W-HALF_W){b_half[HALF_W-1]}}, b_half};
         assign p_narrow = ah_ext * bh_ext;
         assign aw_ext   = {{(PROD_W-DATA_W){a_word[DATA_W-1]}}, a_word};
         assign p_wide   = aw_ext * b_ext;
         assign product  = wide_mode ? p_wide
                                     : {{(PROD_W-DATA_W){p_narrow[DATA_W-1]}}, p_narrow};
      end
   endgenerate

endmodule

// File: rtl/halfmul_accum.sv
// Two's-complement adder with signed overflow detection.
module halfmul_accum #(
   parameter int W = 32
) (
   input  logic [W-1:0] add_a,
   input  logic [W-1:0] add_b,
   output logic [W-1:0] sum,
   output logic         ovf
);

   assign sum = add_a + add_b;
   // Overflow: both inputs share a sign the sum does not.
   assign ovf = (add_a[W-1] == add_b[W-1]) && (sum[W-1] != add_a[W-1]);

endmodule

// File: rtl/halfmul_acc.sv
module halfmul_acc
   import halfmul_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter bit SHARED_MULT = 1'b1,
   localparam int HALF_W = DATA_W / 2,
   localparam int PROD_W = DATA_W + HALF_W,
   localparam int PAIR_W = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [2:0]        op_code,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic [DATA_W-1:0] acc_lo,
   input  logic [DATA_W-1:0] acc_hi,
   input  logic              sel_a_hi,
   input  logic              sel_b_hi,
   output logic              out_valid,
   output logic [DATA_W-1:0] res_lo,
   output logic [DATA_W-1:0] res_hi,
   output logic              ovf_set
);

   generate
      if ((DATA_W % 2) != 0 || DATA_W < 4) begin : g_bad_width
         $error("halfmul_acc: DATA_W must be even and at least 4");
      end
   endgenerate

   // ---------------- operand selection ----------------
   logic [HALF_W-1:0] half_a;
   logic [HALF_W-1:0] half_b;
   logic              wide_mode;

   halfmul_opsel #(.DATA_W(DATA_W)) u_sel_a (
      .word_in (opnd_a),
      .take_hi (sel_a_hi),
      .half_out(half_a)
   );

   halfmul_opsel #(.DATA_W(DATA_W)) u_sel_b (
      .word_in (opnd_b),
      .take_hi (sel_b_hi),
      .half_out(half_b)
   );

   assign wide_mode = hm_is_wide(op_code);

   // ---------------- multiply ----------------
   logic [PROD_W-1:0] product;

   halfmul_mult #(.DATA_W(DATA_W), .SHARED(SHARED_MULT)) u_mult (
      .wide_mode(wide_mode),
      .a_word   (opnd_a),
      .a_half   (half_a),
      .b_half   (half_b),
      .product  (product)
   );

   logic [DATA_W-1:0] prod_low;
   logic [DATA_W-1:0] prod_slice;
   assign prod_low   = product[DATA_W-1:0];
   assign prod_slice = product[PROD_W-1:HALF_W];

   // ---------------- 32-bit accumulate (shared by both accumulating forms) ----------------
   logic [DATA_W-1:0] addend;
   logic [DATA_W-1:0] sum_word;
   logic              sum_ovf;

   assign addend = wide_mode ? prod_slice : prod_low;

   halfmul_accum #(.W(DATA_W)) u_acc_word (
      .add_a(addend),
      .add_b(acc_lo),
      .sum  (sum_word),
      .ovf  (sum_ovf)
   );

   // ---------------- 64-bit pair accumulate ----------------
   logic [PAIR_W-1:0] pair_in;
   logic [PAIR_W-1:0] prod_pair;
   logic [PAIR_W-1:0] pair_sum;

   assign pair_in   = {acc_hi, acc_lo};
   assign prod_pair = {{(PAIR_W-DATA_W){prod_low[DATA_W-1]}}, prod_low};
   assign pair_sum  = pair_in + prod_pair;

   // ---------------- result select ----------------
   logic [DATA_W-1:0] nxt_lo;
   logic [DATA_W-1:0] nxt_hi;
   logic              nxt_ovf;

   always_comb begin
      nxt_lo  = '0;
      nxt_hi  = '0;
      nxt_ovf = 1'b0;
      case (op_code)
         HM_MLA_H: begin
            nxt_lo  = sum_word;
            nxt_ovf = sum_ovf;
         end
         HM_MUL_H: begin
            nxt_lo = prod_low;
         end
         HM_MLA_W: begin
            nxt_lo  = sum_word;
            nxt_ovf = sum_ovf;
         end
         HM_MUL_W: begin
            nxt_lo = prod_slice;
         end
         HM_MLA_L: begin
            nxt_lo = pair_sum[DATA_W-1:0];
            nxt_hi = pair_sum[PAIR_W-1:DATA_W];
         end
         default: begin
            nxt_lo  = '0;
            nxt_hi  = '0;
            nxt_ovf = 1'b0;
         end
      endcase
   end

   // ---------------- output register ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         ovf_set   <= 1'b0;
         res_lo    <= '0;
         res_hi    <= '0;
      end else begin
         out_valid <= in_valid;
         ovf_set   <= in_valid & nxt_ovf;
         if (in_valid) begin
            res_lo <= nxt_lo;
            res_hi <= nxt_hi;
         end
      end
   end

endmodule

// File: rtl/halfmul_acc_checker.sv
module halfmul_acc_checker
   import halfmul_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [2:0]        op_code,
   input logic [DATA_W-1:0] acc_lo,
   input logic              out_valid,
   input logic [DATA_W-1:0] res_lo,
   input logic [DATA_W-1:0] res_hi,
   input logic              ovf_set
);

   // R1: output valid follows input valid by one clock
   p_valid_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R8: overflow pulse only alongside a valid result
   p_pulse_with_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_set |-> out_valid);

   // R4: halfword multiply never flags and clears the high word
   p_mul_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_code == HM_MUL_H) |=> (!ovf_set && res_hi == '0));

   // R5: word-by-half multiply never flags
   p_mulw_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_code == HM_MUL_W) |=> !ovf_set);

   // R7: long accumulate never flags
   p_long_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_code == HM_MLA_L) |=> !ovf_set);

   // R3: a zero accumulate word cannot overflow a halfword product
   p_zero_acc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_code == HM_MLA_H && acc_lo == '0) |=> !ovf_set);

   // R9: reserved codes give a zero pair
   p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_code > 3'd4) |=> (res_lo == '0 && res_hi == '0 && !ovf_set));

   // R10: idle cycles hold the result and drop the strobes
   p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && !ovf_set && $stable(res_lo) && $stable(res_hi)));

endmodule

bind halfmul_acc halfmul_acc_checker #(.DATA_W(DATA_W)) i_halfmul_acc_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .op_code  (op_code),
   .acc_lo   (acc_lo),
   .out_valid(out_valid),
   .res_lo   (res_lo),
   .res_hi   (res_hi),
   .ovf_set  (ovf_set)
);

// File: tb/test_halfmul_acc.sv
`timescale 1ns/1ps
module test_halfmul_acc;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  op_code = 3'd0;
   logic [31:0] opnd_a = '0, opnd_b = '0, acc_lo = '0, acc_hi = '0;
   logic        sel_a_hi = 1'b0, sel_b_hi = 1'b0;
   logic        out_valid;
   logic [31:0] res_lo, res_hi;
   logic        ovf_set;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   halfmul_acc i_halfmul_acc (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .acc_lo(acc_lo), .acc_hi(acc_hi),
      .sel_a_hi(sel_a_hi), .sel_b_hi(sel_b_hi), .out_valid(out_valid),
      .res_lo(res_lo), .res_hi(res_hi), .ovf_set(ovf_set)
   );

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   // Reference computation written from the requirements.
   task automatic model(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] alo, input logic [31:0] ahi,
                        input logic xs, input logic ys,
                        output logic [31:0] elo, output logic [31:0] ehi, output logic eovf);
      longint ah, bh, p, s;
      logic [63:0] pair;
      ah = longint'($signed(xs ? a[31:16] : a[15:0]));
      bh = longint'($signed(ys ? b[31:16] : b[15:0]));
      elo = '0; ehi = '0; eovf = 1'b0;
      case (op)
         3'd0: begin
            p = ah * bh;
            s = p + longint'($signed(alo));
            elo = s[31:0];
            eovf = (s > 64'sd2147483647) || (s < -64'sd2147483648);
         end
         3'd1: begin
            p = ah * bh;
            elo = p[31:0];
         end
         3'd2, 3'd3: begin
            p = longint'($signed(a)) * bh;
            if (op == 3'd3) elo = p[47:16];
            else begin
               s = longint'($signed(p[47:16])) + longint'($signed(alo));
               elo = s[31:0];
               eovf = (s > 64'sd2147483647) || (s < -64'sd2147483648);
            end
         end
         3'd4: begin
            p = ah * bh;
            pair = {ahi, alo} + 64'(p);
            elo = pair[31:0];
            ehi = pair[63:32];
         end
         default: ;
      endcase
   endtask

   // Issue one operation, check the registered outputs one clock later.
   task automatic run_op(input string req, input logic [2:0] op,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] alo, input logic [31:0] ahi,
                         input logic xs, input logic ys);
      logic [31:0] elo, ehi;
      logic        eovf;
      model(op, a, b, alo, ahi, xs, ys, elo, ehi, eovf);
      @(negedge clk);
      in_valid = 1'b1; op_code = op; opnd_a = a; opnd_b = b;
      acc_lo = alo; acc_hi = ahi; sel_a_hi = xs; sel_b_hi = ys;
      @(negedge clk);
      in_valid = 1'b0;
      chk(req, "out_valid", 64'(out_valid), 64'd1);
      chk(req, "res_lo",    64'(res_lo),    64'(elo));
      chk(req, "res_hi",    64'(res_hi),    64'(ehi));
      chk(req, "ovf_set",   64'(ovf_set),   64'(eovf));
   endtask

   task automatic t_reset;
      chk("R1", "reset out_valid", 64'(out_valid), 64'd0);
      chk("R1", "reset res_lo",    64'(res_lo),    64'd0);
      chk("R1", "reset res_hi",    64'(res_hi),    64'd0);
      chk("R1", "reset ovf_set",   64'(ovf_set),   64'd0);
   endtask

   task automatic t_half_select;  // R2: each select picks its own half, signed
      run_op("R2", 3'd1, 32'h0003_FFFE, 32'h0005_0007, 0, 0, 1'b0, 1'b0); // -2*7
      run_op("R2", 3'd1, 32'h0003_FFFE, 32'h0005_0007, 0, 0, 1'b1, 1'b0); // 3*7
      run_op("R2", 3'd1, 32'h0003_FFFE, 32'h0005_0007, 0, 0, 1'b0, 1'b1); // -2*5
      run_op("R2", 3'd1, 32'hFFFD_0001, 32'h8000_0002, 0, 0, 1'b1, 1'b1); // -3*-32768
   endtask

   task automatic t_mla_half;  // R3
      run_op("R3", 3'd0, 32'h0000_8000, 32'h0000_8000, 32'h4000_0000, 0, 1'b0, 1'b0); // +ovf, wraps
      run_op("R3", 3'd0, 32'h0000_8000, 32'h0000_7FFF, 32'h8000_0000, 0, 1'b0, 1'b0); // -ovf
      run_op("R3", 3'd0, 32'h0000_8000, 32'h0000_8000, 32'h3FFF_FFFF, 0, 1'b0, 1'b0); // just fits
      run_op("R3", 3'd0, 32'h1234_0000, 32'h0000_FFFF, 32'h0000_0010, 0, 1'b1, 1'b0);
   endtask

   task automatic t_mul_half;  // R4: extreme product, no flag even though it would "overflow" an acc
      run_op("R4", 3'd1, 32'h0000_8000, 32'h0000_8000, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0);
   endtask

   task automatic t_mul_word;  // R5: sel_a_hi ignored, slice 47:16
      run_op("R5", 3'd3, 32'h8765_4321, 32'h0000_ABCD, 32'h7FFF_FFFF, 0, 1'b0, 1'b0);
      run_op("R5", 3'd3, 32'h8765_4321, 32'h0000_ABCD, 32'h7FFF_FFFF, 0, 1'b1, 1'b0);
      run_op("R5", 3'd3, 32'h7FFF_FFFF, 32'h7FFF_0000, 0, 0, 1'b1, 1'b1);
   endtask

   task automatic t_mla_word;  // R6
      run_op("R6", 3'd2, 32'h7FFF_FFFF, 32'h0000_7FFF, 32'h7FFF_FFFF, 0, 1'b0, 1'b0); // ovf
      run_op("R6", 3'd2, 32'h8000_0000, 32'h0000_7FFF, 32'h8000_0000, 0, 1'b0, 1'b0); // -ovf
      run_op("R6", 3'd2, 32'hFFFF_0000, 32'h0002_0000, 32'h0000_0100, 0, 1'b1, 1'b1); // no ovf
   endtask

   task automatic t_mla_long;  // R7: carry and borrow across words
      run_op("R7", 3'd4, 32'h0000_0001, 32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 1'b0);
      run_op("R7", 3'd4, 32'h0000_FFFF, 32'h0000_0001, 32'h0000_0000, 32'h0000_0001, 1'b0, 1'b0);
      run_op("R7", 3'd4, 32'h0000_8000, 32'h0000_8000, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 1'b0, 1'b0);
   endtask

   task automatic t_pulse;  // R8: flag is a single-cycle pulse
      run_op("R8", 3'd0, 32'h0000_8000, 32'h0000_8000, 32'h7000_0000, 0, 1'b0, 1'b0);
      @(negedge clk);
      chk("R8", "pulse dropped", 64'(ovf_set), 64'd0);
   endtask

   task automatic t_reserved;  // R9
      for (int c = 5; c < 8; c++)
         run_op("R9", 3'(c), 32'h1234_5678, 32'h9ABC_DEF0, 32'h7FFF_FFFF, 32'h1111_1111, 1'b1, 1'b1);
   endtask

   task automatic t_hold;  // R10
      logic [31:0] lo_q, hi_q;
      run_op("R10", 3'd4, 32'h0000_0003, 32'h0000_0005, 32'hAAAA_0000, 32'h5555_0000, 1'b0, 1'b0);
      lo_q = res_lo; hi_q = res_hi;
      opnd_a = 32'hFFFF_FFFF; opnd_b = 32'h1234_1234; op_code = 3'd0; acc_lo = 32'h7FFF_FFFF;
      @(negedge clk);
      chk("R10", "idle out_valid", 64'(out_valid), 64'd0);
      chk("R10", "idle res_lo",    64'(res_lo),    64'(lo_q));
      chk("R10", "idle res_hi",    64'(res_hi),    64'(hi_q));
      chk("R10", "idle ovf_set",   64'(ovf_set),   64'd0);
   endtask

   task automatic t_mixed;  // R1 with varied patterns across all forms
      logic [31:0] s;
      s = 32'hC0FF_EE11;
      for (int i = 0; i < 24; i++) begin
         logic [31:0] a, b, l, h;
         s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5); a = s;
         s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5); b = s;
         s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5); l = s;
         h = ~s;
         run_op("R1", 3'(i % 5), a, b, l, h, s[3], s[7]);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_half_select();
      t_mla_half();
      t_mul_half();
      t_mul_word();
      t_mla_word();
      t_mla_long();
      t_pulse();
      t_reserved();
      t_hold();
      t_mixed();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule